// File: doc/BRIEF.md
# Keyed Overlay Palette and Colour-Bar Source

This block sits in front of a video encoder and its RGB output path and decides, byte by byte, what each path receives. Incoming active video arrives either as one 8-bit stream of interleaved Cb, Y, Cr, Y samples, or as two 8-bit lanes with luma on lane A and alternating Cb/Cr on lane B. For every pixel, an external key pin may substitute a colour from an eight-entry palette. The palette is indexed by a 3-bit overlay input. The encoder path has its own key disable, so overlay graphics can be shown on the RGB output alone.

A configuration bit turns the palette into a test-pattern source. The active line is then split into eight equal bars, and the bars read the palette entries in index order from left to right. No external video is needed in this mode. Outside the active window, both lanes are forwarded untouched, so embedded timing words reach the downstream logic without being decoded.

A small phase state machine tracks the component order. In single-stream mode it cycles through `PH_CB -> PH_Y0 -> PH_CR -> PH_Y1 -> PH_CB`. In dual-lane mode it cycles through `PH_PAIR0 -> PH_PAIR1 -> PH_PAIR0`. `PH_BLANK` is entered from any state when `vid_active` is low. The first active sample after `PH_BLANK`, or any sample with `vid_line_start` high, enters `PH_CB` (single stream) or `PH_PAIR0` (dual lane). A mode change mid-line also forces the state machine back to that first state.

Top module: `pix_overlay_arbiter`

## Requirements
- R1: While `rst_n` is low, all four outputs read 0.
- R2: Every output byte is registered exactly two clock edges after the edge that sampled its input bytes. The key and overlay index go through the same two-stage delay.
- R3: When the sampled `vid_active` is low, `enc_a`/`rgb_a` equal `vid_a` and `enc_b`/`rgb_b` equal `vid_b`. The key is ignored there, and timing words pass through unchanged.
- R4: In single-stream mode, `vid_line_start` marks a Cb byte, and the byte order is Cb, Y, Cr, Y. A luma byte whose own key is high is replaced by the Y byte of the palette entry that `ovl_idx` selects.
- R5: Chroma follows the even pixel. The Cb byte and the following Cr byte are replaced only if the key was high with the Cb (even-pixel) sample. Both take the Cb/Cr bytes of the entry indexed at that even pixel.
- R6: The palette has 8 entries of 24 bits: Y in bits 23:16, Cb in 15:8, Cr in 7:0. An entry is written at a clock edge with `lut_we` high and is used by samples entering at later edges.
- R7: With `cfg_enc_key_off` high, the encoder outputs ignore the key, while the RGB outputs still show the overlay. With it low, both paths are identical.
- R8: With `cfg_bars` high, active video is replaced by palette entries. Pixel p (counted from 0 at the line start) uses entry p/90 for p < 720, and entry 7 beyond that. Chroma uses the bar of the even pixel. The input video has no effect.
- R9: In bar mode, a high key still overrides the bar with the overlay colour.
- R10: With `cfg_dual` high, lane A carries Y for each pixel. Lane B carries Cb on even pixels (the first is at the line start) and Cr on odd pixels. Keying and bars apply to both lanes under the R4, R5 and R8 rules.
- R11: In single-stream mode, lane B is forwarded unchanged on both paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1: Y on lane A, Cb/Cr on lane B |
| cfg_enc_key_off | input | 1 | Disable keying on the encoder path only |
| cfg_bars | input | 1 | Replace active video with palette bars |
| lut_we | input | 1 | Palette write strobe |
| lut_addr | input | 3 | Palette entry to write |
| lut_wdata | input | 24 | Entry value {Y, Cb, Cr} |
| vid_active | input | 1 | Sample lies in the active line |
| vid_line_start | input | 1 | First sample of an active line |
| vid_a | input | 8 | Interleaved stream, or Y in dual-lane mode |
| vid_b | input | 8 | Cb/Cr in dual-lane mode |
| ovl_key | input | 1 | Overlay select for this sample |
| ovl_idx | input | 3 | Palette index for overlay |
| enc_a | output | 8 | Encoder path, lane A |
| enc_b | output | 8 | Encoder path, lane B |
| rgb_a | output | 8 | RGB path, lane A |
| rgb_b | output | 8 | RGB path, lane B |

## Verification
Each result is due at the second rising edge after the edge that samples its input, so a byte driven on one falling edge is read back two falling edges later. The bench pushes every expectation into a two-deep queue together with the stimulus, and compares it when it leaves the queue, away from the active edge. The chroma checks follow the even-pixel rule: a Cr expectation depends on the key given two bytes earlier (single stream) or one pixel earlier (dual lane). The bar sweeps check every byte, including bar edges 89/90 and the clamp past pixel 719. Palette writes are made only while the queue is empty, so each one applies to every later sample.

// File: rtl/pix_ovl_pkg.sv
package pix_ovl_pkg;

    typedef enum logic [2:0] {
        PH_BLANK,
        PH_CB,
        PH_Y0,
        PH_CR,
        PH_Y1,
        PH_PAIR0,
        PH_PAIR1
    } phase_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } lut_entry_t;

    // Sample that opens a chroma pair (even, co-sited pixel)
    function automatic logic is_pair_lead(phase_t p);
        return (p == PH_CB) || (p == PH_PAIR0);
    endfunction

    // Sample that carries a luma value (one per pixel)
    function automatic logic is_luma(phase_t p);
        return (p == PH_Y0) || (p == PH_Y1) || (p == PH_PAIR0) || (p == PH_PAIR1);
    endfunction

    function automatic logic is_dual_phase(phase_t p);
        return (p == PH_PAIR0) || (p == PH_PAIR1);
    endfunction

endpackage

// File: rtl/pix_ovl_lut.sv
module pix_ovl_lut
    import pix_ovl_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int NRD     = 4,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  lut_entry_t                wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output lut_entry_t [NRD-1:0]      rdata
);

    lut_entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/pix_ovl_phase.sv
module pix_ovl_phase
    import pix_ovl_pkg::*;
#(
    parameter int ACTIVE_PIX = 720,
    parameter int NBARS      = 8,
    localparam int BAR_PIX   = ACTIVE_PIX / NBARS,
    localparam int CW        = $clog2(BAR_PIX),
    localparam int BW        = $clog2(NBARS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual,
    input  logic          active,
    input  logic          line_start,
    output phase_t        phase,
    output logic [BW-1:0] bar_luma,
    output logic [BW-1:0] bar_chroma
);

    phase_t          state_q;
    phase_t          nxt;
    phase_t          first;
    logic            restart;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   cnt_cur;
    logic [BW-1:0]   bar_q;
    logic [BW-1:0]   bar_cur;
    logic [BW-1:0]   pair_bar_q;

    assign first = dual ? PH_PAIR0 : PH_CB;

    // next-state (phase of the sample now in the input stage)
    always_comb begin
        nxt = PH_BLANK;
        if (!active) begin
            nxt = PH_BLANK;
        end else if (line_start) begin
            nxt = first;
        end else begin
            unique case (state_q)
                PH_BLANK: nxt = first;
                PH_CB:    nxt = PH_Y0;
                PH_Y0:    nxt = PH_CR;
                PH_CR:    nxt = PH_Y1;
                PH_Y1:    nxt = PH_CB;
                PH_PAIR0: nxt = PH_PAIR1;
                PH_PAIR1: nxt = PH_PAIR0;
                default:  nxt = first;
            endcase
            if (dual != is_dual_phase(nxt)) begin
                nxt = first;
            end
        end
    end

    assign restart    = line_start || (state_q == PH_BLANK);
    assign cnt_cur    = restart ? '0 : cnt_q;
    assign bar_cur    = restart ? '0 : bar_q;
    assign phase      = nxt;
    assign bar_luma   = bar_cur;
    assign bar_chroma = is_pair_lead(nxt) ? bar_cur : pair_bar_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_BLANK;
        end else begin
            state_q <= nxt;
        end
    end

    // pixel position within the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bar_q      <= '0;
            pair_bar_q <= '0;
        end else if (nxt != PH_BLANK) begin
            if (is_luma(nxt) && (cnt_cur == CW'(BAR_PIX - 1))) begin
                cnt_q <= '0;
                bar_q <= (bar_cur == BW'(NBARS - 1)) ? bar_cur : BW'(bar_cur + 1'b1);
            end else if (is_luma(nxt)) begin
                cnt_q <= CW'(cnt_cur + 1'b1);
                bar_q <= bar_cur;
            end else begin
                cnt_q <= cnt_cur;
                bar_q <= bar_cur;
            end
            if (is_pair_lead(nxt)) begin
                pair_bar_q <= bar_cur;
            end
        end
    end

endmodule

// File: rtl/pix_ovl_mux.sv
module pix_ovl_mux
    import pix_ovl_pkg::*;
(
    input  phase_t      phase,
    input  logic        bars,
    input  logic        key_l,
    input  logic        key_c,
    input  logic [7:0]  vid_a,
    input  logic [7:0]  vid_b,
    input  lut_entry_t  ovl_l,
    input  lut_entry_t  ovl_c,
    input  lut_entry_t  bar_l,
    input  lut_entry_t  bar_c,
    output logic [7:0]  out_a,
    output logic [7:0]  out_b
);

    logic [7:0] luma_a;
    logic [7:0] luma_dual;

    assign luma_a    = key_l ? ovl_l.y : (bars ? bar_l.y : vid_a);
    assign luma_dual = luma_a;

    always_comb begin
        out_a = vid_a;
        out_b = vid_b;
        unique case (phase)
            PH_BLANK: begin
                out_a = vid_a;
            end
            PH_CB: out_a = key_c ? ovl_c.cb : (bars ? bar_c.cb : vid_a);
            PH_CR: out_a = key_c ? ovl_c.cr : (bars ? bar_c.cr : vid_a);
            PH_Y0, PH_Y1: out_a = luma_a;
            PH_PAIR0: begin
                out_a = luma_dual;
                out_b = key_c ? ovl_c.cb : (bars ? bar_c.cb : vid_b);
            end
            PH_PAIR1: begin
                out_a = luma_dual;
                out_b = key_c ? ovl_c.cr : (bars ? bar_c.cr : vid_b);
            end
            default: begin
                out_a = vid_a;
            end
        endcase
    end

endmodule

// File: rtl/pix_overlay_arbiter.sv
module pix_overlay_arbiter
    import pix_ovl_pkg::*;
#(
    parameter int ACTIVE_PIX  = 720,
    parameter int LUT_ENTRIES = 8,
    localparam int IW         = $clog2(LUT_ENTRIES),
    localparam int NPATH      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dual,
    input  logic          cfg_enc_key_off,
    input  logic          cfg_bars,
    input  logic          lut_we,
    input  logic [IW-1:0] lut_addr,
    input  logic [23:0]   lut_wdata,
    input  logic          vid_active,
    input  logic          vid_line_start,
    input  logic [7:0]    vid_a,
    input  logic [7:0]    vid_b,
    input  logic          ovl_key,
    input  logic [IW-1:0] ovl_idx,
    output logic [7:0]    enc_a,
    output logic [7:0]    enc_b,
    output logic [7:0]    rgb_a,
    output logic [7:0]    rgb_b
);

    // input stage
    logic          s1_active;
    logic          s1_line_start;
    logic [7:0]    s1_a;
    logic [7:0]    s1_b;
    logic          s1_key;
    logic [IW-1:0] s1_idx;

    // even-pixel hold for chroma
    logic          pair_key_q;
    logic [IW-1:0] pair_idx_q;

    phase_t        phase;
    logic [IW-1:0] bar_luma;
    logic [IW-1:0] bar_chroma;
    logic          key_c_raw;
    logic [IW-1:0] idx_c;

    logic [3:0][IW-1:0] rd_addr;
    lut_entry_t [3:0]   rd_data;

    logic [7:0] path_a [NPATH];
    logic [7:0] path_b [NPATH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_active     <= 1'b0;
            s1_line_start <= 1'b0;
            s1_a          <= '0;
            s1_b          <= '0;
            s1_key        <= 1'b0;
            s1_idx        <= '0;
        end else begin
            s1_active     <= vid_active;
            s1_line_start <= vid_line_start;
            s1_a          <= vid_a;
            s1_b          <= vid_b;
            s1_key        <= ovl_key;
            s1_idx        <= ovl_idx;
        end
    end

    pix_ovl_phase #(
        .ACTIVE_PIX (ACTIVE_PIX),
        .NBARS      (LUT_ENTRIES)
    ) phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual       (cfg_dual),
        .active     (s1_active),
        .line_start (s1_line_start),
        .phase      (phase),
        .bar_luma   (bar_luma),
        .bar_chroma (bar_chroma)
    );

    assign key_c_raw = is_pair_lead(phase) ? s1_key : pair_key_q;
    assign idx_c     = is_pair_lead(phase) ? s1_idx : pair_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_key_q <= 1'b0;
            pair_idx_q <= '0;
        end else if (is_pair_lead(phase)) begin
            pair_key_q <= s1_key;
            pair_idx_q <= s1_idx;
        end
    end

    assign rd_addr[0] = s1_idx;
    assign rd_addr[1] = idx_c;
    assign rd_addr[2] = bar_luma;
    assign rd_addr[3] = bar_chroma;

    pix_ovl_lut #(
        .ENTRIES (LUT_ENTRIES),
        .NRD     (4)
    ) lut_i (
        .clk   (clk),
        .we    (lut_we),
        .waddr (lut_addr),
        .wdata (lut_entry_t'(lut_wdata)),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // path 0: encoder (key may be masked), path 1: RGB (always keyed)
    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic mask;
        if (p == 0) begin : g_enc
            assign mask = cfg_enc_key_off;
        end else begin : g_rgb
            assign mask = 1'b0;
        end
        pix_ovl_mux mux_i (
            .phase (phase),
            .bars  (cfg_bars),
            .key_l (s1_key & ~mask),
            .key_c (key_c_raw & ~mask),
            .vid_a (s1_a),
            .vid_b (s1_b),
            .ovl_l (rd_data[0]),
            .ovl_c (rd_data[1]),
            .bar_l (rd_data[2]),
            .bar_c (rd_data[3]),
            .out_a (path_a[p]),
            .out_b (path_b[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_a <= '0;
            enc_b <= '0;
            rgb_a <= '0;
            rgb_b <= '0;
        end else begin
            enc_a <= path_a[0];
            enc_b <= path_b[0];
            rgb_a <= path_a[1];
            rgb_b <= path_b[1];
        end
    end

endmodule

// File: rtl/pix_overlay_arbiter_chk.sv
module pix_overlay_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_dual,
    input logic       cfg_enc_key_off,
    input logic       cfg_bars,
    input logic       vid_active,
    input logic [7:0] vid_a,
    input logic [7:0] vid_b,
    input logic       ovl_key,
    input logic [7:0] enc_a,
    input logic [7:0] enc_b,
    input logic [7:0] rgb_a,
    input logic [7:0] rgb_b
);

    // edges seen since reset release, saturating
    logic [2:0] warm;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 3'd7) begin
            warm <= warm + 3'd1;
        end
    end

    assign ready = (warm >= 3'd4);

    AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(vid_active, 2)) |->
            (enc_a == $past(vid_a, 2) && rgb_a == $past(vid_a, 2) &&
             enc_b == $past(vid_b, 2) && rgb_b == $past(vid_b, 2))); // R3

    AST_PATHS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(cfg_enc_key_off)) |->
            (enc_a == rgb_a && enc_b == rgb_b)); // R7

    AST_LANE_B_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(cfg_dual)) |->
            (enc_b == $past(vid_b, 2) && rgb_b == $past(vid_b, 2))); // R11

    AST_UNKEYED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(cfg_bars) && !$past(ovl_key, 2) &&
         !$past(ovl_key, 3) && !$past(ovl_key, 4)) |->
            (rgb_a == $past(vid_a, 2))); // R4

endmodule

bind pix_overlay_arbiter pix_overlay_arbiter_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_dual        (cfg_dual),
    .cfg_enc_key_off (cfg_enc_key_off),
    .cfg_bars        (cfg_bars),
    .vid_active      (vid_active),
    .vid_a           (vid_a),
    .vid_b           (vid_b),
    .ovl_key         (ovl_key),
    .enc_a           (enc_a),
    .enc_b           (enc_b),
    .rgb_a           (rgb_a),
    .rgb_b           (rgb_b)
);

// File: tb/pix_overlay_arbiter_tb.sv
module pix_overlay_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dual = 1'b0;
    logic        cfg_enc_key_off = 1'b0;
    logic        cfg_bars = 1'b0;
    logic        lut_we = 1'b0;
    logic [2:0]  lut_addr = '0;
    logic [23:0] lut_wdata = '0;
    logic        vid_active = 1'b0;
    logic        vid_line_start = 1'b0;
    logic [7:0]  vid_a = '0;
    logic [7:0]  vid_b = '0;
    logic        ovl_key = 1'b0;
    logic [2:0]  ovl_idx = '0;
    logic [7:0]  enc_a, enc_b, rgb_a, rgb_b;

    int n_vec = 0;
    int n_bad = 0;

    logic        pv   [2];
    logic [31:0] pexp [2];
    string       ptag [2];

    // {active, line_start, key, idx[2:0], a, b, exp_a, exp_b}; single-stream, both paths keyed
    localparam logic [37:0] VEC [NROWS] = '{
        {1'b0, 1'b0, 1'b0, 3'd0, 8'hFF, 8'h11, 8'hFF, 8'h11},
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h12, 8'h00, 8'h12},
        {1'b1, 1'b1, 1'b0, 3'd0, 8'h55, 8'h13, 8'h55, 8'h13},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h66, 8'h14, 8'h66, 8'h14},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h77, 8'h15, 8'h77, 8'h15},
        {1'b1, 1'b0, 1'b1, 3'd3, 8'h88, 8'h16, 8'h43, 8'h16},
        {1'b1, 1'b0, 1'b1, 3'd2, 8'h50, 8'h17, 8'h82, 8'h17},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h60, 8'h18, 8'h60, 8'h18},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h70, 8'h19, 8'hC2, 8'h19},
        {1'b1, 1'b0, 1'b1, 3'd5, 8'h90, 8'h1A, 8'h45, 8'h1A},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h51, 8'h1B, 8'h51, 8'h1B},
        {1'b1, 1'b0, 1'b1, 3'd7, 8'h61, 8'h1C, 8'h47, 8'h1C},
        {1'b1, 1'b0, 1'b1, 3'd1, 8'h71, 8'h1D, 8'h71, 8'h1D},
        {1'b1, 1'b0, 1'b0, 3'd0, 8'h91, 8'h1E, 8'h91, 8'h1E},
        {1'b0, 1'b0, 1'b1, 3'd4, 8'hAB, 8'h1F, 8'hAB, 8'h1F}
    };

    pix_overlay_arbiter dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_dual        (cfg_dual),
        .cfg_enc_key_off (cfg_enc_key_off),
        .cfg_bars        (cfg_bars),
        .lut_we          (lut_we),
        .lut_addr        (lut_addr),
        .lut_wdata       (lut_wdata),
        .vid_active      (vid_active),
        .vid_line_start  (vid_line_start),
        .vid_a           (vid_a),
        .vid_b           (vid_b),
        .ovl_key         (ovl_key),
        .ovl_idx         (ovl_idx),
        .enc_a           (enc_a),
        .enc_b           (enc_b),
        .rgb_a           (rgb_a),
        .rgb_b           (rgb_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got enc=%h/%h rgb=%h/%h, expected enc=%h/%h rgb=%h/%h", tag,
                     act[31:24], act[23:16], act[15:8], act[7:0],
                     exp[31:24], exp[23:16], exp[15:8], exp[7:0]);
        end
    endtask

    // drive one sample; its outputs are compared two falling edges later
    task automatic step(input logic act, input logic ls, input logic key, input logic [2:0] idx,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic chk, input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (pv[1]) report({enc_a, enc_b, rgb_a, rgb_b}, pexp[1], ptag[1]);
        pv[1]   = pv[0];
        pexp[1] = pexp[0];
        ptag[1] = ptag[0];
        pv[0]   = chk;
        pexp[0] = exp;
        ptag[0] = tag;
        vid_active     = act;
        vid_line_start = ls;
        ovl_key        = key;
        ovl_idx        = idx;
        vid_a          = a;
        vid_b          = b;
    endtask

    task automatic flush();
        step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 32'h0, "");
        step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 32'h0, "");
        step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 32'h0, "");
    endtask

    task automatic lut_write(input logic [2:0] addr, input logic [23:0] val);
        @(negedge clk);
        lut_we    = 1'b1;
        lut_addr  = addr;
        lut_wdata = val;
        @(negedge clk);
        lut_we    = 1'b0;
    endtask

    function automatic int bar_of(input int p);
        return (p / 90 > 7) ? 7 : p / 90;
    endfunction

    function automatic logic [23:0] palette(input int i);
        return {8'(8'h40 + i), 8'(8'h80 + i), 8'(8'hC0 + i)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no end of run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        pv[0] = 1'b0;
        pv[1] = 1'b0;

        // R1: reset holds outputs at zero despite live inputs
        vid_active = 1'b1;
        vid_a      = 8'hAA;
        vid_b      = 8'h55;
        ovl_key    = 1'b1;
        repeat (4) @(negedge clk);
        report({enc_a, enc_b, rgb_a, rgb_b}, 32'h0, "R1 outputs in reset");
        vid_active = 1'b0;
        ovl_key    = 1'b0;
        vid_a      = '0;
        vid_b      = '0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) lut_write(3'(i), palette(i));

        // table walk: single stream, keyed both paths
        for (int i = 0; i < NROWS; i++) begin : row
            logic [37:0] v;
            v = VEC[i];
            step(v[37], v[36], v[35], v[34:32], v[31:24], v[23:16], 1'b1,
                 {v[15:8], v[7:0], v[15:8], v[7:0]},
                 $sformatf("R2/R3/R4/R5/R11 table row %0d", i));
        end
        flush();

        // R6: rewrite entry 3 and use it
        lut_write(3'd3, 24'hAABBCC);
        step(1'b1, 1'b1, 1'b1, 3'd3, 8'h01, 8'h00, 1'b1, 32'hBB00BB00, "R6 new Cb");
        step(1'b1, 1'b0, 1'b1, 3'd3, 8'h02, 8'h00, 1'b1, 32'hAA00AA00, "R6 new Y");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h03, 8'h00, 1'b1, 32'hCC00CC00, "R6 new Cr");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h99, 8'h00, 1'b1, 32'h99009900, "R6 plain Y");
        flush();
        lut_write(3'd3, palette(3));

        // R7: encoder keying disabled, RGB still keyed
        cfg_enc_key_off = 1'b1;
        step(1'b1, 1'b1, 1'b1, 3'd4, 8'h30, 8'h07, 1'b1, 32'h30078407, "R7 Cb");
        step(1'b1, 1'b0, 1'b1, 3'd4, 8'h31, 8'h07, 1'b1, 32'h31074407, "R7 Y0");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h32, 8'h07, 1'b1, 32'h3207C407, "R7 Cr");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h33, 8'h07, 1'b1, 32'h33073307, "R7 Y1");
        flush();
        cfg_enc_key_off = 1'b0;

        // R8/R9: bars, single stream, one keyed luma at pixel 300
        cfg_bars = 1'b1;
        for (int j = 0; j < 1444; j++) begin : bar_s
            int k;
            int ph;
            logic [7:0] ea;
            logic       key;
            k   = j / 4;
            ph  = j % 4;
            key = (j == 601);
            case (ph)
                0:       ea = 8'(8'h80 + bar_of(2 * k));
                1:       ea = 8'(8'h40 + bar_of(2 * k));
                2:       ea = 8'(8'hC0 + bar_of(2 * k));
                default: ea = 8'(8'h40 + bar_of(2 * k + 1));
            endcase
            if (key) ea = 8'h46;
            step(1'b1, (j == 0), key, key ? 3'd6 : 3'd0, 8'(j) ^ 8'h5A, 8'(j), 1'b1,
                 {ea, 8'(j), ea, 8'(j)}, $sformatf("R8 R9 bar byte %0d", j));
        end
        flush();
        cfg_bars = 1'b0;

        // R10: dual lane with even-pixel chroma
        cfg_dual = 1'b1;
        step(1'b1, 1'b1, 1'b0, 3'd0, 8'h10, 8'h20, 1'b1, 32'h10201020, "R10 p0");
        step(1'b1, 1'b0, 1'b1, 3'd1, 8'h11, 8'h21, 1'b1, 32'h41214121, "R10 p1 luma only");
        step(1'b1, 1'b0, 1'b1, 3'd2, 8'h12, 8'h22, 1'b1, 32'h42824282, "R10 p2 keyed pair");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h13, 8'h23, 1'b1, 32'h13C213C2, "R10 p3 held Cr");
        flush();

        // R8/R10: bars in dual lane
        cfg_bars = 1'b1;
        for (int p = 0; p < 722; p++) begin : bar_d
            logic [7:0] ea;
            logic [7:0] eb;
            ea = 8'(8'h40 + bar_of(p));
            eb = (p % 2 == 0) ? 8'(8'h80 + bar_of(p)) : 8'(8'hC0 + bar_of(p - 1));
            step(1'b1, (p == 0), 1'b0, 3'd0, 8'(p), 8'(p) ^ 8'hA5, 1'b1,
                 {ea, eb, ea, eb}, $sformatf("R8 R10 dual bar pixel %0d", p));
        end
        flush();
        cfg_bars = 1'b0;
        cfg_dual = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule